// File: doc/BRIEF.md
# Multiplexed ADC Scan Controller with Set-Point Alarms

This block drives a multiplexed 16-bit analog-to-digital converter through a start/done handshake. It decides which input to convert next, collects each result, and compares it against a low and a high set point held for that input. The outcome of each comparison is kept as a per-input alarm status that the host can read at any time. The inputs can be wired as 32 single-ended or 16 differential channels. Four more test channels let diagnostics exercise the whole input path, including the converter.

Conversions run in one of two modes:
- **Demand mode**: the host asks for one channel and gets one result.
- **Auto mode**: the block scans a set of channels in ascending order. The set is either every analog channel of the current wiring or the channels picked by an enable mask.

An auto scan can repeat at a fixed interval set by an internal pacer. It can also run once per trigger, where the trigger comes from the pacer, an external pin or a software pulse. Two sticky flags report a finished scan and a trigger that arrived while a scan was still running.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `adc_start`, `busy`, `res_valid`, `scan_done`, `overrun` and every bit of `stat_lo` and `stat_hi` are 0.
- R2: With `cfg_auto`=0, a one-cycle `dem_req` naming a valid channel causes exactly one conversion of `dem_ch`. `res_valid` is high for one cycle, in the cycle after the cycle in which `adc_done` was high, and carries that channel and the converter data. With `cfg_auto`=1, `dem_req` has no effect.
- R3: Channel indices 0..31 are the analog inputs and 32..35 are the test channels. With `cfg_diff`=1, only 0..15 of the analog range are valid, and 16..31 are never converted, whether by scan or by demand.
- R4: In auto mode with `cfg_use_mask`=0, a scan converts every valid analog channel (test channels excluded) once, in ascending index order.
- R5: With `cfg_use_mask`=1, a scan converts exactly the channels whose `cfg_chan_mask` bit is set and that are valid, test channels included, in ascending order.
- R6: `adc_start` is a one-cycle pulse. No new `adc_start` occurs until the converter has answered the previous one with `adc_done`.
- R7: After a conversion of channel c with value v, `stat_lo[c]`=1 exactly when v < low set point, and `stat_hi[c]`=1 exactly when v > high set point (unsigned). A value equal to a set point raises neither bit.
- R8: With `cfg_auto`=1 and `cfg_cont`=1, a scan starts on every pacer event, and pacer events come every `cfg_pacer_period`+1 cycles.
- R9: With `cfg_cont`=0, one scan runs per trigger from the source picked by `cfg_trig_src`: 0 pacer, 1 rising edge of `ext_trig`, 2 `sw_trig` pulse, 3 none. Triggers from the other sources start nothing.
- R10: A selected trigger that arrives while a scan is in progress sets `overrun` and does not start or lengthen a scan.
- R11: `scan_done` is set when the result of the last channel in a scan has been taken. If the scan set is empty, it is set at once on the trigger. `flag_clr` clears `scan_done` and `overrun`.
- R12: After reset, the low set points are 0 and the high set points are 0xFFFF, so no conversion raises an alarm until the set points are written through `sp_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_auto | input | 1 | 1 auto scan mode, 0 demand mode |
| cfg_diff | input | 1 | 1 differential wiring (16 analog channels), 0 single-ended (32) |
| cfg_use_mask | input | 1 | Scan only the channels enabled in the mask |
| cfg_chan_mask | input | 36 | Per-channel scan enable |
| cfg_cont | input | 1 | Repeat scans on every pacer event |
| cfg_trig_src | input | 2 | Single-shot trigger source: 0 pacer, 1 external, 2 software, 3 none |
| cfg_pacer_period | input | 16 | Pacer reload value |
| ext_trig | input | 1 | External trigger level (rising edge used) |
| sw_trig | input | 1 | Software trigger pulse |
| dem_req | input | 1 | Demand conversion request |
| dem_ch | input | 6 | Channel for a demand conversion |
| flag_clr | input | 1 | Clear the scan-complete and overrun flags |
| sp_we | input | 1 | Set-point write strobe |
| sp_ch | input | 6 | Channel whose set points are written |
| sp_lo | input | 16 | Low set point to write |
| sp_hi | input | 16 | High set point to write |
| adc_start | output | 1 | Conversion start pulse to the converter |
| adc_ch | output | 6 | Channel selected for conversion |
| adc_done | input | 1 | Converter reports the result is ready |
| adc_data | input | 16 | Converter result |
| res_valid | output | 1 | One-cycle result strobe |
| res_ch | output | 6 | Channel of the result |
| res_data | output | 16 | Result value |
| stat_lo | output | 36 | Per-channel below-low alarm |
| stat_hi | output | 36 | Per-channel above-high alarm |
| scan_done | output | 1 | Sticky scan-complete flag |
| overrun | output | 1 | Sticky trigger-during-scan flag |
| busy | output | 1 | A conversion or scan is in progress |

## Verification
The assertions check the handshake on every cycle:
- each start is a single-cycle pulse issued while busy;
- the block leaves busy only after a done;
- each result strobe follows a done;
- every started channel is in range, and none falls in the differential gap;
- the two sticky flags rise only after the events that may cause them.

Only the bench's scenarios can show the properties that need a whole stimulus sequence to be judged. These are the exact order and membership of the converted channels for each wiring and mask, the alarm bits against set points including the equality cases, the pacer spacing, the selection of the trigger source, and the rejection of demand requests.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CONV = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;

  localparam logic [1:0] TRG_PACER = 2'd0;
  localparam logic [1:0] TRG_EXT   = 2'd1;
  localparam logic [1:0] TRG_SOFT  = 2'd2;

  // Unsigned limit arithmetic; operands are zero-extended by the caller.
  function automatic logic is_below(input logic [31:0] v, input logic [31:0] lim);
    return v < lim;
  endfunction

  function automatic logic is_above(input logic [31:0] v, input logic [31:0] lim);
    return v > lim;
  endfunction

endpackage

// File: rtl/adc_scan_pacer.sv
module adc_scan_pacer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period,
  output logic          tick
);

  logic [PW-1:0] cnt_q;

  assign tick = en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= period;
    end else if (cnt_q == '0) begin
      cnt_q <= period;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NSE   = 32,
  parameter int NTEST = 4,
  parameter int DW    = 16,
  localparam int NCH  = NSE + NTEST,
  localparam int CW   = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           auto_mode,
  input  logic           diff_mode,
  input  logic           use_mask,
  input  logic [NCH-1:0] chan_mask,
  input  logic           cont_mode,
  input  logic [1:0]     trig_src,
  input  logic           pacer_tick,
  input  logic           ext_trig,
  input  logic           sw_trig,
  input  logic           dem_req,
  input  logic [CW-1:0]  dem_ch,
  input  logic           flag_clr,
  output logic           adc_start,
  output logic [CW-1:0]  adc_ch,
  input  logic           adc_done,
  input  logic [DW-1:0]  adc_data,
  output logic           res_valid,
  output logic [CW-1:0]  res_ch,
  output logic [DW-1:0]  res_data,
  output logic           scan_done,
  output logic           overrun,
  output logic           busy,
  output logic           conv_ev,
  output logic           trig_ev
);

  seq_state_e    st_q;
  logic [CW-1:0] ch_q;
  logic          is_dem_q;
  logic          ext_q;
  logic          done_q, ovr_q;
  logic          rv_q;
  logic [CW-1:0] rch_q;
  logic [DW-1:0] rdat_q;

  logic [NCH-1:0] valid_vec, analog_vec, scan_set;
  logic [CW:0]    first_hit, next_hit;
  logic           sel_trig, dem_go;

  // Channel validity for the current wiring.
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    if (g < NSE / 2) begin : g_always
      assign valid_vec[g]  = 1'b1;
      assign analog_vec[g] = 1'b1;
    end else if (g < NSE) begin : g_se_only
      assign valid_vec[g]  = ~diff_mode;
      assign analog_vec[g] = 1'b1;
    end else begin : g_test
      assign valid_vec[g]  = 1'b1;
      assign analog_vec[g] = 1'b0;
    end
  end

  assign scan_set = use_mask ? (chan_mask & valid_vec) : (valid_vec & analog_vec);

  // Lowest enabled index at or above 'from'; MSB flags a hit.
  function automatic logic [CW:0] seek(input logic [NCH-1:0] en, input int from);
    logic [CW:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (en[i] && i >= from) r = {1'b1, CW'(i)};
    end
    return r;
  endfunction

  assign first_hit = seek(scan_set, 0);
  assign next_hit  = seek(scan_set, int'(ch_q) + 1);

  always_comb begin
    if (cont_mode) begin
      sel_trig = pacer_tick;
    end else begin
      case (trig_src)
        TRG_PACER: sel_trig = pacer_tick;
        TRG_EXT:   sel_trig = ext_trig & ~ext_q;
        TRG_SOFT:  sel_trig = sw_trig;
        default:   sel_trig = 1'b0;
      endcase
    end
  end

  assign trig_ev   = auto_mode && sel_trig;
  assign dem_go    = !auto_mode && dem_req && (int'(dem_ch) < NCH) && valid_vec[dem_ch];
  assign conv_ev   = (st_q == SQ_WAIT) && adc_done;
  assign busy      = (st_q != SQ_IDLE);
  assign adc_start = (st_q == SQ_CONV);
  assign adc_ch    = ch_q;
  assign res_valid = rv_q;
  assign res_ch    = rch_q;
  assign res_data  = rdat_q;
  assign scan_done = done_q;
  assign overrun   = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      ch_q     <= '0;
      is_dem_q <= 1'b0;
      ext_q    <= 1'b0;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
      rv_q     <= 1'b0;
      rch_q    <= '0;
      rdat_q   <= '0;
    end else begin
      ext_q <= ext_trig;
      rv_q  <= 1'b0;
      if (flag_clr) begin
        done_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      case (st_q)
        SQ_IDLE: begin
          if (dem_go) begin
            ch_q     <= dem_ch;
            is_dem_q <= 1'b1;
            st_q     <= SQ_CONV;
          end else if (trig_ev) begin
            is_dem_q <= 1'b0;
            if (first_hit[CW]) begin
              ch_q <= first_hit[CW-1:0];
              st_q <= SQ_CONV;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        SQ_CONV: st_q <= SQ_WAIT;
        SQ_WAIT: begin
          if (adc_done) begin
            rv_q   <= 1'b1;
            rch_q  <= ch_q;
            rdat_q <= adc_data;
            if (is_dem_q) begin
              st_q <= SQ_IDLE;
            end else if (next_hit[CW]) begin
              ch_q <= next_hit[CW-1:0];
              st_q <= SQ_CONV;
            end else begin
              st_q   <= SQ_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
      if (trig_ev && st_q != SQ_IDLE) ovr_q <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_limit_bank.sv
module adc_limit_bank
  import adc_scan_pkg::*;
#(
  parameter int NCH = 36,
  parameter int DW  = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sp_we,
  input  logic [CW-1:0]  sp_ch,
  input  logic [DW-1:0]  sp_lo,
  input  logic [DW-1:0]  sp_hi,
  input  logic           upd,
  input  logic [CW-1:0]  upd_ch,
  input  logic [DW-1:0]  upd_data,
  output logic [NCH-1:0] stat_lo,
  output logic [NCH-1:0] stat_hi
);

  logic [DW-1:0] lo_r [NCH];
  logic [DW-1:0] hi_r [NCH];
  logic [DW-1:0] sel_lo, sel_hi;
  logic          below, above;

  // One shared pair of comparators behind a set-point mux.
  always_comb begin
    sel_lo = '0;
    sel_hi = '1;
    for (int i = 0; i < NCH; i++) begin
      if (upd_ch == CW'(i)) begin
        sel_lo = lo_r[i];
        sel_hi = hi_r[i];
      end
    end
  end

  assign below = is_below(32'(upd_data), 32'(sel_lo));
  assign above = is_above(32'(upd_data), 32'(sel_hi));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_r[g]    <= '0;
        hi_r[g]    <= '1;
        stat_lo[g] <= 1'b0;
        stat_hi[g] <= 1'b0;
      end else begin
        if (sp_we && sp_ch == CW'(g)) begin
          lo_r[g] <= sp_lo;
          hi_r[g] <= sp_hi;
        end
        if (upd && upd_ch == CW'(g)) begin
          stat_lo[g] <= below;
          stat_hi[g] <= above;
        end
      end
    end
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int NSE   = 32,
  parameter int NTEST = 4,
  parameter int DW    = 16,
  parameter int PW    = 16,
  localparam int NCH  = NSE + NTEST,
  localparam int CW   = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_auto,
  input  logic           cfg_diff,
  input  logic           cfg_use_mask,
  input  logic [NCH-1:0] cfg_chan_mask,
  input  logic           cfg_cont,
  input  logic [1:0]     cfg_trig_src,
  input  logic [PW-1:0]  cfg_pacer_period,
  input  logic           ext_trig,
  input  logic           sw_trig,
  input  logic           dem_req,
  input  logic [CW-1:0]  dem_ch,
  input  logic           flag_clr,
  input  logic           sp_we,
  input  logic [CW-1:0]  sp_ch,
  input  logic [DW-1:0]  sp_lo,
  input  logic [DW-1:0]  sp_hi,
  output logic           adc_start,
  output logic [CW-1:0]  adc_ch,
  input  logic           adc_done,
  input  logic [DW-1:0]  adc_data,
  output logic           res_valid,
  output logic [CW-1:0]  res_ch,
  output logic [DW-1:0]  res_data,
  output logic [NCH-1:0] stat_lo,
  output logic [NCH-1:0] stat_hi,
  output logic           scan_done,
  output logic           overrun,
  output logic           busy
);

  logic pacer_tick;
  logic conv_ev;
  logic trig_ev;

  adc_scan_pacer #(.PW(PW)) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cfg_auto),
    .period (cfg_pacer_period),
    .tick   (pacer_tick)
  );

  adc_scan_seq #(.NSE(NSE), .NTEST(NTEST), .DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_mode  (cfg_auto),
    .diff_mode  (cfg_diff),
    .use_mask   (cfg_use_mask),
    .chan_mask  (cfg_chan_mask),
    .cont_mode  (cfg_cont),
    .trig_src   (cfg_trig_src),
    .pacer_tick (pacer_tick),
    .ext_trig   (ext_trig),
    .sw_trig    (sw_trig),
    .dem_req    (dem_req),
    .dem_ch     (dem_ch),
    .flag_clr   (flag_clr),
    .adc_start  (adc_start),
    .adc_ch     (adc_ch),
    .adc_done   (adc_done),
    .adc_data   (adc_data),
    .res_valid  (res_valid),
    .res_ch     (res_ch),
    .res_data   (res_data),
    .scan_done  (scan_done),
    .overrun    (overrun),
    .busy       (busy),
    .conv_ev    (conv_ev),
    .trig_ev    (trig_ev)
  );

  adc_limit_bank #(.NCH(NCH), .DW(DW)) u_limits (
    .clk      (clk),
    .rst_n    (rst_n),
    .sp_we    (sp_we),
    .sp_ch    (sp_ch),
    .sp_lo    (sp_lo),
    .sp_hi    (sp_hi),
    .upd      (conv_ev),
    .upd_ch   (adc_ch),
    .upd_data (adc_data),
    .stat_lo  (stat_lo),
    .stat_hi  (stat_hi)
  );

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NSE   = 32,
  parameter int NTEST = 4,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_start,
  input logic [CW-1:0] adc_ch,
  input logic          adc_done,
  input logic          busy,
  input logic          res_valid,
  input logic          scan_done,
  input logic          overrun,
  input logic          trig_ev,
  input logic          cfg_diff
);

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy);

  assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(adc_done));

  assert_result_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(adc_done && busy));

  assert_chan_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (int'(adc_ch) < NSE + NTEST));

  assert_diff_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && cfg_diff && int'(adc_ch) < NSE) |-> (int'(adc_ch) < NSE / 2));

  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(busy && trig_ev));

  assert_done_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_done) |-> ($past(trig_ev) || $past(adc_done && busy)));

endmodule

bind adc_scan_ctrl adc_scan_chk #(.NSE(NSE), .NTEST(NTEST), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adc_start (adc_start),
  .adc_ch    (adc_ch),
  .adc_done  (adc_done),
  .busy      (busy),
  .res_valid (res_valid),
  .scan_done (scan_done),
  .overrun   (overrun),
  .trig_ev   (trig_ev),
  .cfg_diff  (cfg_diff)
);

// File: tb/adc_scan_ctrl_tb.sv
module adc_scan_ctrl_tb;

  localparam int NCH = 36;
  localparam int CW  = 6;
  localparam int LAT = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_auto = 0, cfg_diff = 0, cfg_use_mask = 0, cfg_cont = 0;
  logic [NCH-1:0] cfg_chan_mask = '0;
  logic [1:0] cfg_trig_src = 2'd3;
  logic [15:0] cfg_pacer_period = '0;
  logic ext_trig = 0, sw_trig = 0, dem_req = 0, flag_clr = 0, sp_we = 0;
  logic [CW-1:0] dem_ch = '0, sp_ch = '0;
  logic [15:0] sp_lo = '0, sp_hi = '0;
  logic adc_start, adc_done = 0, res_valid, scan_done, overrun, busy;
  logic [CW-1:0] adc_ch, res_ch;
  logic [15:0] adc_data = '0, res_data;
  logic [NCH-1:0] stat_lo, stat_hi;

  always #2 clk = ~clk;

  adc_scan_ctrl u_dut (.*);

  int total = 0, bad = 0;
  int cyc = 0;
  int conv_n = 0;
  logic [15:0] blo [NCH];
  logic [15:0] bhi [NCH];
  logic [NCH-1:0] elo = '0, ehi = '0;
  int rec_ch [512];
  int nrec = 0;
  int st_cyc [512];
  int st_ch [512];
  int nst = 0;
  int exp_ch [64];
  int nexp = 0;
  bit done_flag = 0;

  function void check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [15:0] aval(int ch, int n);
    return 16'((ch * 1777 + n * 311 + 123) % 65536);
  endfunction

  function automatic bit bvalid(int ch, bit diff);
    return (ch < 16) || (ch < 32 && !diff) || (ch >= 32);
  endfunction

  function void build_exp(bit diff, bit usem, logic [NCH-1:0] m);
    nexp = 0;
    for (int c = 0; c < NCH; c++) begin
      if (bvalid(c, diff) && (usem ? m[c] : (c < 32))) begin
        exp_ch[nexp] = c;
        nexp++;
      end
    end
  endfunction

  // Converter model and result monitor, all at the falling edge.
  initial begin
    bit mbusy = 0, pdone = 0;
    int cnt = 0, cur = 0, pch = 0;
    logic [15:0] pdat = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (pdone) begin
          check(res_valid && int'(res_ch) == pch && res_data == pdat, "R2",
                "result after done", {res_valid, 10'(res_ch), res_data}, {1'b1, 10'(pch), pdat});
          elo[pch] = pdat < blo[pch];
          ehi[pch] = pdat > bhi[pch];
          if (nrec < 512) rec_ch[nrec] = pch;
          nrec++;
        end else if (res_valid) begin
          check(0, "R2", "unexpected res_valid", 1, 0);
        end
      end
      adc_done = 0;
      if (adc_start) begin
        if (mbusy) check(0, "R6", "start while waiting", 1, 0);
        mbusy = 1; cnt = LAT; cur = int'(adc_ch);
        if (nst < 512) begin st_cyc[nst] = cyc; st_ch[nst] = cur; end
        nst++;
      end else if (mbusy) begin
        cnt--;
        if (cnt == 0) begin
          adc_done = 1;
          adc_data = aval(cur, conv_n);
          pch = cur; pdat = adc_data;
          conv_n++;
          mbusy = 0;
        end
      end
      pdone = adc_done;
    end
  end

  task automatic wait_idle();
    int k = 0;
    repeat (3) @(negedge clk);
    while ((busy || adc_done) && k < 4000) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_sw();
    @(negedge clk) sw_trig = 1;
    @(negedge clk) sw_trig = 0;
  endtask

  task automatic wr_sp(int ch, logic [15:0] lo, logic [15:0] hi);
    @(negedge clk);
    sp_we = 1; sp_ch = CW'(ch); sp_lo = lo; sp_hi = hi;
    @(negedge clk) sp_we = 0;
    blo[ch] = lo; bhi[ch] = hi;
  endtask

  task automatic clear_logs();
    nrec = 0; nst = 0;
  endtask

  task automatic cmp_list(string req);
    bit ok = (nrec == nexp);
    for (int i = 0; i < nexp && i < nrec; i++) if (rec_ch[i] != exp_ch[i]) ok = 0;
    check(ok, req, "scan channel list/count", nrec, nexp);
  endtask

  task automatic cmp_status(string req);
    check(stat_lo == elo, req, "stat_lo", stat_lo, elo);
    check(stat_hi == ehi, req, "stat_hi", stat_hi, ehi);
  endtask

  task automatic flags_clear();
    @(negedge clk) flag_clr = 1;
    @(negedge clk) flag_clr = 0;
  endtask

  task automatic demand(int ch);
    @(negedge clk) begin dem_req = 1; dem_ch = CW'(ch); end
    @(negedge clk) dem_req = 0;
    wait_idle();
  endtask

  initial begin
    repeat (5000 * 30) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    for (int c = 0; c < NCH; c++) begin blo[c] = 16'h0; bhi[c] = 16'hFFFF; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!adc_start && !busy && !res_valid && !scan_done && !overrun, "R1",
          "control outputs in reset", {adc_start, busy, res_valid, scan_done, overrun}, 0);
    check(stat_lo == '0 && stat_hi == '0, "R1", "status in reset", {stat_lo, stat_hi}, 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check(!adc_start && !busy && !scan_done && !overrun, "R1", "first cycle after reset",
          {adc_start, busy, scan_done, overrun}, 0);

    // R4 + R12: full single-ended scan with reset set points
    cfg_auto = 1; cfg_trig_src = 2'd2; clear_logs();
    pulse_sw(); wait_idle();
    build_exp(0, 0, '0); cmp_list("R4");
    check(stat_lo == '0 && stat_hi == '0, "R12", "no alarms with reset set points",
          {stat_lo, stat_hi}, 0);
    check(scan_done, "R11", "scan_done after scan", scan_done, 1);
    check(!overrun, "R10", "no overrun on clean scan", overrun, 0);
    flags_clear();
    check(!scan_done, "R11", "flag_clr clears scan_done", scan_done, 0);

    // R7: set points then full scan
    for (int c = 0; c < NCH; c++) wr_sp(c, 16'((c * 1500) % 65536), 16'((c * 1500 + 20000) % 65536));
    clear_logs(); pulse_sw(); wait_idle();
    cmp_list("R4"); cmp_status("R7");

    // R3: differential, all channels
    cfg_diff = 1; clear_logs(); flags_clear(); pulse_sw(); wait_idle();
    build_exp(1, 0, '0); cmp_list("R3");

    // R5: mask in diff mode (gap bits and test channels set)
    cfg_use_mask = 1;
    cfg_chan_mask = 36'h0;
    cfg_chan_mask[0] = 1; cfg_chan_mask[9] = 1; cfg_chan_mask[15] = 1;
    cfg_chan_mask[17] = 1; cfg_chan_mask[20] = 1; cfg_chan_mask[33] = 1; cfg_chan_mask[35] = 1;
    clear_logs(); pulse_sw(); wait_idle();
    build_exp(1, 1, cfg_chan_mask); cmp_list("R5"); cmp_status("R7");
    cfg_diff = 0; clear_logs(); pulse_sw(); wait_idle();
    build_exp(0, 1, cfg_chan_mask); cmp_list("R5");

    // R9: external source ignores software pulses, starts on rising edge once
    cfg_trig_src = 2'd1; clear_logs();
    pulse_sw(); repeat (20) @(negedge clk);
    check(nst == 0, "R9", "sw pulse ignored with ext source", nst, 0);
    @(negedge clk) ext_trig = 1;
    repeat (6) @(negedge clk); ext_trig = 0;
    wait_idle();
    cmp_list("R9");
    cfg_trig_src = 2'd3; clear_logs();
    pulse_sw(); @(negedge clk) ext_trig = 1; @(negedge clk) ext_trig = 0;
    repeat (20) @(negedge clk);
    check(nst == 0, "R9", "source 3 starts nothing", nst, 0);

    // R10: overrun
    cfg_trig_src = 2'd2; cfg_use_mask = 0; flags_clear(); clear_logs();
    pulse_sw(); repeat (20) @(negedge clk); pulse_sw(); wait_idle();
    build_exp(0, 0, '0); cmp_list("R10");
    check(overrun, "R10", "overrun set", overrun, 1);
    flags_clear();
    check(!overrun && !scan_done, "R11", "flag_clr clears both", {overrun, scan_done}, 0);

    // R11: empty scan set
    cfg_use_mask = 1; cfg_chan_mask = '0; clear_logs();
    pulse_sw(); repeat (4) @(negedge clk);
    check(scan_done && nst == 0, "R11", "empty set done at once", {scan_done, 8'(nst)}, 9'h100);

    // R2: demand mode
    cfg_auto = 0; cfg_use_mask = 0; clear_logs();
    demand(34);
    check(nrec == 1 && rec_ch[0] == 34, "R2", "demand converts one channel", nrec * 64 + rec_ch[0], 64 + 34);
    cfg_diff = 1; clear_logs(); demand(20);
    check(nst == 0, "R3", "demand of gap channel rejected", nst, 0);
    cfg_diff = 0; cfg_auto = 1; cfg_trig_src = 2'd3; clear_logs(); demand(5);
    check(nst == 0, "R2", "demand ignored in auto mode", nst, 0);
    cfg_auto = 0;

    // R7: equality corner cases through demand conversions on channel 5
    v = aval(5, conv_n); wr_sp(5, v, v); clear_logs(); demand(5);
    check(!stat_lo[5] && !stat_hi[5], "R7", "equal to both set points", {stat_lo[5], stat_hi[5]}, 0);
    v = aval(5, conv_n);
    if (v != 16'hFFFF) begin
      wr_sp(5, v + 16'd1, 16'hFFFF); demand(5);
      check(stat_lo[5] && !stat_hi[5], "R7", "below low", {stat_lo[5], stat_hi[5]}, 2'b10);
    end
    v = aval(5, conv_n);
    if (v != 16'h0) begin
      wr_sp(5, 16'h0, v - 16'd1); demand(5);
      check(!stat_lo[5] && stat_hi[5], "R7", "above high", {stat_lo[5], stat_hi[5]}, 2'b01);
    end
    cmp_status("R7");

    // R8: pacer-driven continuous scans
    cfg_pacer_period = 16'd60; cfg_use_mask = 1;
    cfg_chan_mask = '0; cfg_chan_mask[3] = 1; cfg_chan_mask[7] = 1; cfg_chan_mask[33] = 1;
    clear_logs(); flags_clear();
    @(negedge clk) begin cfg_auto = 1; cfg_cont = 1; end
    repeat (320) @(negedge clk);
    @(negedge clk) cfg_cont = 0;
    wait_idle();
    begin
      int prev = -1, nint = 0;
      bit ok = 1;
      for (int i = 0; i < nst && i < 512; i++) begin
        if (st_ch[i] == 3) begin
          if (prev >= 0) begin
            if (st_cyc[i] - prev != 61) ok = 0;
            nint++;
          end
          prev = st_cyc[i];
        end
      end
      check(ok && nint >= 3, "R8", "pacer scan spacing", nint, 3);
    end
    check(!overrun, "R10", "no overrun with short scans", overrun, 0);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule